// File: doc/BRIEF.md
# Keyed watchdog timer

A bus-attached watchdog that counts down once per tick-enable pulse (nominally every 10 ms) and, when the count runs out, raises a reset request for a fixed number of clocks. Every change of run state is guarded by a 16-bit key. A correct key reloads the counter. A two-step key pair stops it. A separate key resumes a stopped counter. A write with any other value has no effect.

Software programs a 15-bit reload value and enables the warning interrupt. It then feeds the counter with the feed key before the count reaches zero. One tick before expiry a warning event is latched. It is visible on `warn_irq` while the mask bit is set, and a write of 1 acknowledges it. After an expiry the status register shows an expired code until software clears it with a key. While a debugger is attached, counting pauses unless the debug-run bit is set.

The block contains two state machines.

The run machine has three states:
- `S_RUN`: counting.
- `S_FIRE`: reset request held.
- `S_HALT`: stopped.

Its transitions are:
- expire: `S_RUN`→`S_FIRE`.
- fire-done: `S_FIRE`→`S_RUN`.
- stop: `S_RUN` or `S_FIRE`→`S_HALT`.
- feed-start: `S_HALT`→`S_RUN`, with a reload.
- resume: `S_HALT`→`S_RUN`, keeping the held count.

The key machine has two states, `K_IDLE` and `K_ARMED`. Its transitions are:
- arm: `K_IDLE`→`K_ARMED`.
- fire-stop: `K_ARMED`→`K_IDLE`, issuing a stop.
- disarm: `K_ARMED`→`K_IDLE`, on any other write.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the block is running, the count and the reload value are both 6000 (0x1770), the status and the stop-state register read 0x0000, no event is pending, and `warn_irq` and `rst_req` are low.
- R2: A write to offset 0x04 stores bits 14:0 as the reload value, which reads back masked to 0x7FFF. The write does not change the live count.
- R3: Writing 0xFEED to offset 0x00 loads the count from the reload value and starts counting. Any other value written there is ignored.
- R4: Each counting tick decrements the count while running. Offset 0x14 reads the count in bits 14:0, and bit 15 reads 1 in a cycle where a counting tick is present. While halted the count is frozen.
- R5: Writing 0x2BAD to offset 0x08 arms a stop. If the next write is 0xCAFE to offset 0x0C, the counter halts; any other write disarms. Offset 0x0C reads 0xDABE while halted and 0x0000 otherwise, and 0xCAFE written without arming is ignored.
- R6: Writing 0xACED to offset 0x1C resumes a halted counter from its held count.
- R7: A counting tick with the count at 1 or 0 expires the watchdog. `rst_req` goes high from the next cycle for FIRE_CYCLES (4) clocks, the count reloads from the last reload value, and ticks are ignored while `rst_req` is high.
- R8: An expiry sets offset 0x10 to 0xCFE8. Writing 0xE8B4 there returns it to 0x0000, any other value is ignored, and an expiry in the same cycle as the clear wins.
- R9: A counting tick that takes the count from 2 to 1 sets the event bit 0 of offset 0x20. `warn_irq` equals that event ANDed with bit 0 of offset 0x24. Writing 1 to bit 0 of 0x20 clears the event by the next cycle, unless a set occurs in the same cycle.
- R10: While bit 0 of offset 0x28 is 1, the event is set every cycle, so an acknowledge cannot clear it.
- R11: Offset 0x18 reads `dbg_attached` in bit 1 and a writable debug-run bit in bit 0. Ticks are not counted while a debugger is attached and the debug-run bit is 0.
- R12: A feed written in the same cycle as an expiring tick wins. The count reloads and no reset request or expired status follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (6) | Byte offset of the register |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| tick_en | input | 1 | One-cycle pulse at the count rate |
| dbg_attached | input | 1 | High while a debugger is attached |
| warn_irq | output | 1 | Masked pre-expiry warning |
| rst_req | output | 1 | System reset request |

## Verification
Two things can land in the same clock edge: a feed write and the tick that would expire the counter. The bench first walks the count down to 1. It then issues the 0xFEED write in the very cycle `tick_en` is high. At the following falling edge it checks that the count equals the reload value, that `rst_req` stayed low and that the status is still 0x0000. A second overlap, a forced event against an acknowledge in the same cycle, is judged by reading the event bit back as still set.

// File: rtl/wdog_keyed_pkg.sv
package wdog_keyed_pkg;

    localparam int REG_W = 16;

    // register offsets (software decodes these)
    localparam logic [7:0] OFS_FEED   = 8'h00;
    localparam logic [7:0] OFS_RELOAD = 8'h04;
    localparam logic [7:0] OFS_STOP1  = 8'h08;
    localparam logic [7:0] OFS_STOP2  = 8'h0C;
    localparam logic [7:0] OFS_STATUS = 8'h10;
    localparam logic [7:0] OFS_COUNT  = 8'h14;
    localparam logic [7:0] OFS_DEBUG  = 8'h18;
    localparam logic [7:0] OFS_RESUME = 8'h1C;
    localparam logic [7:0] OFS_EVENT  = 8'h20;
    localparam logic [7:0] OFS_MASK   = 8'h24;
    localparam logic [7:0] OFS_FORCE  = 8'h28;

    // keys and read codes
    localparam logic [REG_W-1:0] KEY_FEED     = 16'hFEED;
    localparam logic [REG_W-1:0] KEY_STOP1    = 16'h2BAD;
    localparam logic [REG_W-1:0] KEY_STOP2    = 16'hCAFE;
    localparam logic [REG_W-1:0] KEY_RESUME   = 16'hACED;
    localparam logic [REG_W-1:0] KEY_CLEAR    = 16'hE8B4;
    localparam logic [REG_W-1:0] CODE_HALTED  = 16'hDABE;
    localparam logic [REG_W-1:0] CODE_EXPIRED = 16'hCFE8;

    typedef enum logic [1:0] {S_RUN, S_FIRE, S_HALT} run_state_e;
    typedef enum logic {K_IDLE, K_ARMED} key_state_e;

endpackage

// File: rtl/wdog_keyed_keyseq.sv
module wdog_keyed_keyseq
    import wdog_keyed_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic              stop_o
);

    key_state_e ks_q, ks_d;
    logic       hit_arm, hit_fire;

    assign hit_arm  = wr_i && (addr_i == ADDR_W'(OFS_STOP1)) && (wdata_i == KEY_STOP1);
    assign hit_fire = wr_i && (addr_i == ADDR_W'(OFS_STOP2)) && (wdata_i == KEY_STOP2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ks_q <= K_IDLE;
        else        ks_q <= ks_d;
    end

    always_comb begin
        ks_d = ks_q;
        unique case (ks_q)
            K_IDLE:  if (hit_arm) ks_d = K_ARMED;                   // arm
            K_ARMED: begin
                if (hit_fire)              ks_d = K_IDLE;           // fire-stop
                else if (wr_i && !hit_arm) ks_d = K_IDLE;           // disarm
            end
            default: ks_d = K_IDLE;
        endcase
    end

    always_comb begin
        stop_o = (ks_q == K_ARMED) && hit_fire;
    end

    // R5: the armed state is only ever entered on the first key
    a_r5_arm_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ks_q == K_ARMED) |-> $past(hit_arm));

    // R5: any write other than a key leaves the armed state
    a_r5_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_q == K_ARMED && wr_i && !hit_arm) |=> ks_q == K_IDLE);

endmodule

// File: rtl/wdog_keyed_core.sv
module wdog_keyed_core
    import wdog_keyed_pkg::*;
#(
    parameter int CNT_W          = 15,
    parameter int DEFAULT_RELOAD = 6000,
    parameter int FIRE_CYCLES    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             feed_i,
    input  logic             stop_i,
    input  logic             resume_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             counting_o,
    output logic             halted_o,
    output logic             expire_o,
    output logic             warn_o,
    output logic             rst_req_o
);

    localparam int              FW        = (FIRE_CYCLES > 1) ? $clog2(FIRE_CYCLES) : 1;
    localparam logic [FW-1:0]   FIRE_LAST = FW'(FIRE_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TWO  = CNT_W'(2);

    run_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [FW-1:0]    fire_q, fire_d;
    logic             expire_d, warn_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_RUN;
            cnt_q  <= CNT_W'(DEFAULT_RELOAD);
            fire_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            fire_q <= fire_d;
        end
    end

    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        fire_d   = fire_q;
        expire_d = 1'b0;
        warn_d   = 1'b0;
        unique case (st_q)
            S_RUN: begin
                if (stop_i) begin
                    st_d = S_HALT;                                  // stop
                end else if (feed_i) begin
                    cnt_d = reload_i;
                end else if (tick_i) begin
                    if (cnt_q <= CNT_ONE) begin
                        st_d     = S_FIRE;                          // expire
                        cnt_d    = reload_i;
                        fire_d   = '0;
                        expire_d = 1'b1;
                    end else begin
                        cnt_d  = cnt_q - CNT_ONE;
                        warn_d = (cnt_q == CNT_TWO);
                    end
                end
            end
            S_FIRE: begin
                if (feed_i) cnt_d = reload_i;
                if (stop_i) begin
                    st_d = S_HALT;                                  // stop
                end else if (fire_q == FIRE_LAST) begin
                    st_d = S_RUN;                                   // fire-done
                end else begin
                    fire_d = fire_q + FW'(1);
                end
            end
            S_HALT: begin
                if (feed_i) begin
                    st_d  = S_RUN;                                  // feed-start
                    cnt_d = reload_i;
                end else if (resume_i) begin
                    st_d = S_RUN;                                   // resume
                end
            end
            default: st_d = S_RUN;
        endcase
    end

    always_comb begin
        cnt_o      = cnt_q;
        counting_o = (st_q == S_RUN);
        halted_o   = (st_q == S_HALT);
        rst_req_o  = (st_q == S_FIRE);
        expire_o   = expire_d;
        warn_o     = warn_d;
    end

    // R7: a reset request starts only after an expiring tick
    a_r7_fire_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> ($past(tick_i) && $past(cnt_q) <= CNT_ONE));

    // R5: halting only follows a completed stop sequence
    a_r5_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_HALT && $past(st_q) != S_HALT) |-> $past(stop_i));

    // R4: a halted count stays frozen unless fed
    a_r4_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_HALT && !feed_i) |=> $stable(cnt_q));

    // R12: a feed while running always wins over a tick
    a_r12_feed_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (feed_i && st_q == S_RUN && !stop_i) |=> (!rst_req_o && cnt_q == $past(reload_i)));

endmodule

// File: rtl/wdog_keyed_irq.sv
module wdog_keyed_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic warn_i,
    input  logic ack_i,
    input  logic wr_mask_i,
    input  logic wr_force_i,
    input  logic wbit_i,
    output logic evt_o,
    output logic mask_o,
    output logic force_o,
    output logic irq_o
);

    logic evt_q, mask_q, force_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q   <= 1'b0;
            mask_q  <= 1'b0;
            force_q <= 1'b0;
        end else begin
            if (warn_i || force_q) evt_q <= 1'b1;
            else if (ack_i)        evt_q <= 1'b0;
            if (wr_mask_i)  mask_q  <= wbit_i;
            if (wr_force_i) force_q <= wbit_i;
        end
    end

    always_comb begin
        evt_o   = evt_q;
        mask_o  = mask_q;
        force_o = force_q;
        irq_o   = evt_q && mask_q;
    end

    // R9: an acknowledge with no set source clears the event next cycle
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !warn_i && !force_q) |=> !evt_q);

    // R9: the event only rises from a warning or a force
    a_r9_evt_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_q) |-> $past(warn_i || force_q));

    // R10: a held force keeps the event set
    a_r10_force_holds: assert property (@(posedge clk) disable iff (!rst_n)
        force_q |=> evt_q);

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdog_keyed_pkg::*;
#(
    parameter int ADDR_W         = 6,
    parameter int CNT_W          = 15,
    parameter int DEFAULT_RELOAD = 6000,
    parameter int FIRE_CYCLES    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              tick_en,
    input  logic              dbg_attached,
    output logic              warn_irq,
    output logic              rst_req
);

    logic             wr_feed, wr_reload, wr_status, wr_debug, wr_resume;
    logic             wr_event, wr_mask, wr_force;
    logic             feed, resume, stop, clear, cnt_tick;
    logic [CNT_W-1:0] reload_q, cnt;
    logic             expired_q, dbg_run_q;
    logic             counting, halted, expire, warn;
    logic             evt, mask, force_bit;

    assign wr_feed   = bus_we && (bus_addr == ADDR_W'(OFS_FEED));
    assign wr_reload = bus_we && (bus_addr == ADDR_W'(OFS_RELOAD));
    assign wr_status = bus_we && (bus_addr == ADDR_W'(OFS_STATUS));
    assign wr_debug  = bus_we && (bus_addr == ADDR_W'(OFS_DEBUG));
    assign wr_resume = bus_we && (bus_addr == ADDR_W'(OFS_RESUME));
    assign wr_event  = bus_we && (bus_addr == ADDR_W'(OFS_EVENT));
    assign wr_mask   = bus_we && (bus_addr == ADDR_W'(OFS_MASK));
    assign wr_force  = bus_we && (bus_addr == ADDR_W'(OFS_FORCE));

    assign feed     = wr_feed   && (bus_wdata == KEY_FEED);
    assign resume   = wr_resume && (bus_wdata == KEY_RESUME);
    assign clear    = wr_status && (bus_wdata == KEY_CLEAR);
    assign cnt_tick = tick_en && (!dbg_attached || dbg_run_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q  <= CNT_W'(DEFAULT_RELOAD);
            expired_q <= 1'b0;
            dbg_run_q <= 1'b0;
        end else begin
            if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
            if (expire)     expired_q <= 1'b1;
            else if (clear) expired_q <= 1'b0;
            if (wr_debug)  dbg_run_q <= bus_wdata[0];
        end
    end

    wdog_keyed_keyseq #(.ADDR_W(ADDR_W)) u_keyseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_we),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .stop_o  (stop)
    );

    wdog_keyed_core #(
        .CNT_W          (CNT_W),
        .DEFAULT_RELOAD (DEFAULT_RELOAD),
        .FIRE_CYCLES    (FIRE_CYCLES)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .feed_i     (feed),
        .stop_i     (stop),
        .resume_i   (resume),
        .tick_i     (cnt_tick),
        .reload_i   (reload_q),
        .cnt_o      (cnt),
        .counting_o (counting),
        .halted_o   (halted),
        .expire_o   (expire),
        .warn_o     (warn),
        .rst_req_o  (rst_req)
    );

    wdog_keyed_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .warn_i     (warn),
        .ack_i      (wr_event && bus_wdata[0]),
        .wr_mask_i  (wr_mask),
        .wr_force_i (wr_force),
        .wbit_i     (bus_wdata[0]),
        .evt_o      (evt),
        .mask_o     (mask),
        .force_o    (force_bit),
        .irq_o      (warn_irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_RELOAD): bus_rdata[CNT_W-1:0] = reload_q;
            ADDR_W'(OFS_STOP2):  bus_rdata = halted ? CODE_HALTED : '0;
            ADDR_W'(OFS_STATUS): bus_rdata = expired_q ? CODE_EXPIRED : '0;
            ADDR_W'(OFS_COUNT): begin
                bus_rdata[CNT_W-1:0] = cnt;
                bus_rdata[15]        = cnt_tick && counting;
            end
            ADDR_W'(OFS_DEBUG):  bus_rdata[1:0] = {dbg_attached, dbg_run_q};
            ADDR_W'(OFS_EVENT):  bus_rdata[0]   = evt;
            ADDR_W'(OFS_MASK):   bus_rdata[0]   = mask;
            ADDR_W'(OFS_FORCE):  bus_rdata[0]   = force_bit;
            default:             bus_rdata = '0;
        endcase
    end

    // R8: the expired status rises only with an expiry
    a_r8_status_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired_q) |-> $past(expire));

    // R8: the clear key drops the status unless an expiry coincides
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !expire) |=> !expired_q);

    // R11: no counting tick reaches the core while a debugger holds it
    a_r11_dbg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_attached && !dbg_run_q && counting && !feed && !stop) |=> $stable(cnt));

endmodule

// File: tb/wdog_keyed_bench.sv
`timescale 1ns/1ps
module wdog_keyed_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        dbg_attached = 1'b0;
    logic        warn_irq, rst_req;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    wdog_keyed u_wdog_keyed (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
        .dbg_attached(dbg_attached), .warn_irq(warn_irq), .rst_req(rst_req)
    );

    // {we, waddr, wdata, tick, raddr, expected}
    localparam int NV = 18;
    localparam logic [45:0] VEC [NV] = '{
        {1'b1, 6'h04, 16'hFFFF, 1'b0, 6'h04, 16'h7FFF},  // R2 masked
        {1'b1, 6'h04, 16'h0005, 1'b0, 6'h14, 16'h1770},  // R2 no reload
        {1'b1, 6'h00, 16'h1234, 1'b0, 6'h14, 16'h1770},  // R3 bad key
        {1'b1, 6'h00, 16'hFEED, 1'b0, 6'h14, 16'h0005},  // R3 feed
        {1'b0, 6'h00, 16'h0000, 1'b1, 6'h14, 16'h0004},  // R4 tick
        {1'b1, 6'h0C, 16'hCAFE, 1'b0, 6'h0C, 16'h0000},  // R5 unarmed
        {1'b1, 6'h08, 16'h2BAD, 1'b0, 6'h0C, 16'h0000},  // R5 armed
        {1'b1, 6'h0C, 16'hCAFE, 1'b0, 6'h0C, 16'hDABE},  // R5 halted
        {1'b0, 6'h00, 16'h0000, 1'b1, 6'h14, 16'h0004},  // R5 frozen
        {1'b1, 6'h1C, 16'hACED, 1'b0, 6'h0C, 16'h0000},  // R6 resume
        {1'b0, 6'h00, 16'h0000, 1'b1, 6'h14, 16'h0003},  // R6 held count
        {1'b1, 6'h08, 16'h2BAD, 1'b0, 6'h0C, 16'h0000},  // R5 arm
        {1'b1, 6'h04, 16'h0005, 1'b0, 6'h0C, 16'h0000},  // R5 break
        {1'b1, 6'h0C, 16'hCAFE, 1'b0, 6'h0C, 16'h0000},  // R5 disarmed
        {1'b1, 6'h24, 16'h0001, 1'b0, 6'h24, 16'h0001},  // R9 mask
        {1'b0, 6'h00, 16'h0000, 1'b1, 6'h14, 16'h0002},  // R4 tick
        {1'b0, 6'h00, 16'h0000, 1'b1, 6'h20, 16'h0001},  // R9 warning
        {1'b1, 6'h20, 16'h0001, 1'b0, 6'h20, 16'h0000}   // R9 ack
    };

    function automatic string vreq(int i);
        case (i)
            0, 1:                   return "R2";
            2, 3:                   return "R3";
            4, 15:                  return "R4";
            5, 6, 7, 8, 11, 12, 13: return "R5";
            9, 10:                  return "R6";
            default:                return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic we, input logic [5:0] a, input logic [15:0] d, input logic t);
        bus_we = we; bus_addr = a; bus_wdata = d; tick_en = t;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; tick_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-requirements actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(6'h14, v); chk("R1 count", v, 16'h1770);
        rd(6'h04, v); chk("R1 reload", v, 16'h1770);
        rd(6'h10, v); chk("R1 status", v, 16'h0000);
        rd(6'h0C, v); chk("R1 stop state", v, 16'h0000);
        rd(6'h20, v); chk("R1 event", v, 16'h0000);
        chk("R1 outputs", {14'd0, warn_irq, rst_req}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][45], VEC[i][44:39], VEC[i][38:23], VEC[i][22]);
            rd(VEC[i][21:16], v);
            chk(vreq(i), v, VEC[i][15:0]);
        end

        // R7 expiry from count 1
        step(1'b0, 6'h00, 16'h0, 1'b1);
        chk("R7 rst_req", {15'd0, rst_req}, 16'h0001);
        rd(6'h14, v); chk("R7 reload", v, 16'h0005);
        rd(6'h10, v); chk("R8 expired", v, 16'hCFE8);
        n = 1;
        tick_en = 1'b1;                       // ignored while firing
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (rst_req) n++; else break;
        end
        tick_en = 1'b0;
        chk("R7 pulse length", 16'(n), 16'd4);
        rd(6'h14, v); chk("R7 no tick while firing", v, 16'h0005);

        // R8 status clear
        step(1'b1, 6'h10, 16'h1234, 1'b0);
        rd(6'h10, v); chk("R8 bad clear", v, 16'hCFE8);
        step(1'b1, 6'h10, 16'hE8B4, 1'b0);
        rd(6'h10, v); chk("R8 clear", v, 16'h0000);

        // R12 feed in the expiring cycle
        for (int k = 0; k < 4; k++) step(1'b0, 6'h00, 16'h0, 1'b1);
        rd(6'h14, v); chk("R12 setup", v, 16'h0001);
        step(1'b1, 6'h00, 16'hFEED, 1'b1);
        chk("R12 no rst_req", {15'd0, rst_req}, 16'h0000);
        rd(6'h14, v); chk("R12 reload", v, 16'h0005);
        @(negedge clk);
        chk("R12 no rst_req later", {15'd0, rst_req}, 16'h0000);
        rd(6'h10, v); chk("R12 status", v, 16'h0000);

        // R11 debug hold
        dbg_attached = 1'b1;
        rd(6'h18, v); chk("R11 attached", v, 16'h0002);
        step(1'b0, 6'h00, 16'h0, 1'b1);
        rd(6'h14, v); chk("R11 held", v, 16'h0005);
        tick_en = 1'b1;
        rd(6'h14, v); chk("R4 no flag when held", v, 16'h0005);
        tick_en = 1'b0;
        step(1'b1, 6'h18, 16'h0001, 1'b0);
        rd(6'h18, v); chk("R11 run bit", v, 16'h0003);
        tick_en = 1'b1;
        rd(6'h14, v); chk("R4 update flag", v, 16'h8005);
        @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
        rd(6'h14, v); chk("R11 counts with run bit", v, 16'h0004);
        dbg_attached = 1'b0;
        step(1'b1, 6'h18, 16'h0000, 1'b0);

        // R10 force and R9 masking
        step(1'b1, 6'h20, 16'h0001, 1'b0);
        rd(6'h20, v); chk("R9 ack", v, 16'h0000);
        step(1'b1, 6'h28, 16'h0001, 1'b0);
        step(1'b0, 6'h00, 16'h0, 1'b0);
        rd(6'h20, v); chk("R10 forced", v, 16'h0001);
        chk("R9 irq unmasked", {15'd0, warn_irq}, 16'h0001);
        step(1'b1, 6'h20, 16'h0001, 1'b0);
        rd(6'h20, v); chk("R10 ack loses", v, 16'h0001);
        step(1'b1, 6'h24, 16'h0000, 1'b0);
        chk("R9 irq masked", {15'd0, warn_irq}, 16'h0000);
        step(1'b1, 6'h28, 16'h0000, 1'b0);
        step(1'b1, 6'h20, 16'h0001, 1'b0);
        rd(6'h20, v); chk("R10 cleared after force off", v, 16'h0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule